// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block turns a set of programmed timing counts into the SCL waveform and the SDA event strobes for an I2C master. A bus engine asks for one segment at a time (a data bit, a START or a STOP), and the block drives SCL and pulses the strobes at the cycle where the engine may move SDA or sample it. Every count is a number of prescaled ticks. One tick lasts DIV+1 input clocks. A phase programmed with count N lasts N+1 ticks.

Two timing sets are presented as 32-bit words, one for fast mode and one for high-speed mode. A mode select picks one set. The chosen set and the input-filter count are latched when a segment is accepted, so they hold for the whole segment. A START asked for while SCL is low becomes a repeated start: SCL first stays low for a release interval while SDA is let go. Segments can be chained with no gap, because a new request is taken in the last cycle of the current segment.

Top module: `scl_timing_gen`

## Requirements
- R1: A bit segment holds SCL low for (LO+1)·(DIV+1) clocks and then high for (HI+1)·(DIV+1) + 8 + 2·FLT clocks. This makes the whole period (DIV+1)·(LO+HI+2) + 8 + 2·FLT clocks. SCL changes only at phase boundaries.
- R2: In a bit segment, sda_set_stb pulses once, while SCL is low, P·(DIV+1) clocks after SCL falls. P = min(HOLD, LO, max(0, LO+1−DSU)).
- R3: sample_stb and seg_done pulse together on the last clock of a bit segment, while SCL is still high.
- R4: A START requested while the line is idle-high keeps SCL high. sda_fall_stb pulses on clock (SSU+1)·(DIV+1)−1. seg_done pulses (SHD+1)·(DIV+1) clocks later, on the last high clock. SCL is low afterwards.
- R5: A START requested while SCL is low first holds SCL low for (REL+1)·(DIV+1) clocks, with sda_rise_stb on its first clock. The R4 sequence follows.
- R6: A STOP holds SCL low for (LO+1)·(DIV+1) clocks, with sda_fall_stb at the R2 position. It then holds SCL high for (PSU+1)·(DIV+1) clocks, with sda_rise_stb and seg_done on the last one. SCL stays high after the STOP.
- R7: The field positions are as follows. Word 1: START setup [31:24], START hold [23:16], STOP setup [15:8]. Word 2: data setup [31:24], SCL low [15:8], SCL high [7:0]. Word 3: DIV [23:16], release [7:0]. The hold word: data hold [7:0]. All other bits are ignored.
- R8: hs_sel=1 selects the high-speed words and hs_sel=0 selects the fast-mode words. The data hold word is shared by both sets. The select is sampled when a request is accepted, and a later change has no effect on the running segment.
- R9: ready is high while idle and on the last clock of a segment. A request seen with ready high starts its segment on the next clock. req_kind is encoded as 0 bit, 1 START, 2 STOP, and 3 no operation. A kind-3 request changes nothing.
- R10: After reset, scl is high, ready is high and all strobes are low.
- R11: flt_cycles is sampled at acceptance, and a later change has no effect on the running segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_sel | input | 1 | 1 selects the high-speed timing set |
| flt_cycles | input | 3 | Input-filter cycle count |
| fs_word1 | input | 32 | Fast set: START setup, START hold, STOP setup |
| fs_word2 | input | 32 | Fast set: data setup, SCL low, SCL high |
| fs_word3 | input | 32 | Fast set: divider, repeated-start release |
| hs_word1 | input | 32 | High-speed set, word 1 layout |
| hs_word2 | input | 32 | High-speed set, word 2 layout |
| hs_word3 | input | 32 | High-speed set, word 3 layout |
| hold_word | input | 32 | Data hold count in [7:0], shared by both sets |
| req | input | 1 | Segment request |
| req_kind | input | 2 | 0 bit, 1 START, 2 STOP, 3 no operation |
| ready | output | 1 | A request is taken this clock |
| scl | output | 1 | SCL level (1 = released high) |
| sda_fall_stb | output | 1 | SDA may be pulled low now |
| sda_rise_stb | output | 1 | SDA may be released now |
| sda_set_stb | output | 1 | Next data bit may be placed on SDA |
| sample_stb | output | 1 | Sample SDA for the current bit |
| seg_done | output | 1 | Last clock of the segment |

## Verification
Most internal faults move an edge at the ports. A wrong tick counter or prescaler shifts the next SCL edge by at least one clock inside the same segment. A wrong overhead or latched set stretches the period before the following segment begins. A wrong line-level memory shows up at the next START, as a release phase that is present or missing. Each segment is therefore compared clock by clock, across its whole length, against a model built from the requirements. This catches a fault within one segment of its cause.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;

    localparam int CNT_W     = 8;
    localparam int FLT_W     = 3;
    localparam int OVH_W     = 5;
    localparam int OVH_BASE  = 8;
    localparam int WORD_W    = 32;

    typedef enum logic [1:0] {
        SEG_BIT   = 2'd0,
        SEG_START = 2'd1,
        SEG_STOP  = 2'd2,
        SEG_NONE  = 2'd3
    } seg_kind_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_REL,
        PH_SSU,
        PH_SHD,
        PH_BLO,
        PH_BHI,
        PH_BOV,
        PH_PLO,
        PH_PSU
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] st_su;
        logic [CNT_W-1:0] st_hd;
        logic [CNT_W-1:0] sp_su;
        logic [CNT_W-1:0] d_su;
        logic [CNT_W-1:0] d_hd;
        logic [CNT_W-1:0] rel;
    } tim_set_t;

    // Tick inside the low phase at which SDA may move: no earlier than the
    // hold count, no later than setup allows, never past the last low tick.
    function automatic logic [CNT_W-1:0] change_tick(
        input logic [CNT_W-1:0] lo,
        input logic [CNT_W-1:0] su,
        input logic [CNT_W-1:0] hd
    );
        logic [CNT_W:0]   room;
        logic [CNT_W-1:0] p;
        if (({1'b0, lo} + 1'b1) > {1'b0, su})
            room = {1'b0, lo} + 1'b1 - {1'b0, su};
        else
            room = '0;
        p = hd;
        if ({1'b0, p} > room) p = room[CNT_W-1:0];
        if (p > lo) p = lo;
        return p;
    endfunction

endpackage

// File: rtl/scl_tim_select.sv
module scl_tim_select
    import scl_tim_pkg::*;
(
    input  logic              hs_sel,
    input  logic [WORD_W-1:0] fs_w1,
    input  logic [WORD_W-1:0] fs_w2,
    input  logic [WORD_W-1:0] fs_w3,
    input  logic [WORD_W-1:0] hs_w1,
    input  logic [WORD_W-1:0] hs_w2,
    input  logic [WORD_W-1:0] hs_w3,
    input  logic [WORD_W-1:0] hold_w,
    output tim_set_t          sel
);
    localparam int NSETS = 2;

    logic [WORD_W-1:0] w1 [NSETS];
    logic [WORD_W-1:0] w2 [NSETS];
    logic [WORD_W-1:0] w3 [NSETS];
    tim_set_t          sets [NSETS];

    assign w1[0] = fs_w1;  assign w1[1] = hs_w1;
    assign w2[0] = fs_w2;  assign w2[1] = hs_w2;
    assign w3[0] = fs_w3;  assign w3[1] = hs_w3;

    for (genvar g = 0; g < NSETS; g++) begin : g_dec
        assign sets[g].st_su = w1[g][31:24];
        assign sets[g].st_hd = w1[g][23:16];
        assign sets[g].sp_su = w1[g][15:8];
        assign sets[g].d_su  = w2[g][31:24];
        assign sets[g].lo    = w2[g][15:8];
        assign sets[g].hi    = w2[g][7:0];
        assign sets[g].div   = w3[g][23:16];
        assign sets[g].rel   = w3[g][7:0];
        assign sets[g].d_hd  = hold_w[7:0];
    end

    assign sel = sets[hs_sel];

    logic unused_bits;
    assign unused_bits = ^{fs_w1[7:0], fs_w2[23:16], fs_w3[31:24], fs_w3[15:8],
                           hs_w1[7:0], hs_w2[23:16], hs_w3[31:24], hs_w3[15:8],
                           hold_w[31:8]};

endmodule

// File: rtl/scl_tim_ticker.sv
module scl_tim_ticker
    import scl_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] div,
    input  logic [CNT_W-1:0] lim,
    output logic             first_clk,
    output logic [CNT_W-1:0] tick_idx,
    output logic             run_end
);
    logic [CNT_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre      <= '0;
            tick_idx <= '0;
        end else if (load) begin
            pre      <= '0;
            tick_idx <= '0;
        end else if (pre == div) begin
            pre      <= '0;
            tick_idx <= tick_idx + 1'b1;
        end else begin
            pre      <= pre + 1'b1;
        end
    end

    assign first_clk = (pre == '0);
    assign run_end   = (pre == div) && (tick_idx == lim);

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pre <= div); // R1

endmodule

// File: rtl/scl_tim_fsm.sv
module scl_tim_fsm
    import scl_tim_pkg::*;
#(
    parameter bit FLT_DOUBLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  seg_kind_e        kind,
    input  tim_set_t         sel,
    input  logic [FLT_W-1:0] flt,
    input  logic             first_clk,
    input  logic [CNT_W-1:0] tick_idx,
    input  logic             run_end,
    output logic             load,
    output logic [CNT_W-1:0] div,
    output logic [CNT_W-1:0] lim,
    output logic             ready,
    output logic             scl,
    output logic             sda_fall_stb,
    output logic             sda_rise_stb,
    output logic             sda_set_stb,
    output logic             sample_stb,
    output logic             seg_done
);
    phase_e           phase, nxt;
    tim_set_t         cfg;
    seg_kind_e        kind_q;
    logic             line_hi;
    logic [OVH_W-1:0] ovh_q, ovh_new, xcnt;
    logic             ph_end, seg_last, accept, lvl_after;
    logic [CNT_W-1:0] pos;

    if (FLT_DOUBLE) begin : g_flt_dbl
        assign ovh_new = OVH_W'(OVH_BASE) + {1'b0, flt, 1'b0};
    end else begin : g_flt_sgl
        assign ovh_new = OVH_W'(OVH_BASE) + {2'b00, flt};
    end

    assign div = cfg.div;
    assign pos = change_tick(cfg.lo, cfg.d_su, cfg.d_hd);

    always_comb begin
        unique case (phase)
            PH_REL:          lim = cfg.rel;
            PH_SSU:          lim = cfg.st_su;
            PH_SHD:          lim = cfg.st_hd;
            PH_BLO, PH_PLO:  lim = cfg.lo;
            PH_BHI:          lim = cfg.hi;
            PH_PSU:          lim = cfg.sp_su;
            default:         lim = '0;
        endcase
    end

    assign ph_end    = (phase == PH_BOV) ? (xcnt == ovh_q - 1'b1)
                                         : ((phase != PH_IDLE) && run_end);
    assign seg_last  = ph_end && (phase == PH_SHD || phase == PH_BOV || phase == PH_PSU);
    assign ready     = (phase == PH_IDLE) || seg_last;
    assign lvl_after = seg_last ? (kind_q == SEG_STOP) : line_hi;
    assign accept    = req && ready && (kind != SEG_NONE);
    assign load      = accept || ph_end;

    always_comb begin
        nxt = phase;
        if (accept) begin
            unique case (kind)
                SEG_START: nxt = lvl_after ? PH_SSU : PH_REL;
                SEG_STOP:  nxt = PH_PLO;
                default:   nxt = PH_BLO;
            endcase
        end else if (ph_end) begin
            unique case (phase)
                PH_REL:  nxt = PH_SSU;
                PH_SSU:  nxt = PH_SHD;
                PH_BLO:  nxt = PH_BHI;
                PH_BHI:  nxt = PH_BOV;
                PH_PLO:  nxt = PH_PSU;
                default: nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cfg     <= '0;
            kind_q  <= SEG_BIT;
            line_hi <= 1'b1;
            ovh_q   <= OVH_W'(OVH_BASE);
            xcnt    <= '0;
        end else begin
            phase <= nxt;
            if (accept) begin
                cfg    <= sel;
                kind_q <= kind;
                ovh_q  <= ovh_new;
            end
            if (seg_last) line_hi <= (kind_q == SEG_STOP);
            if (load)                  xcnt <= '0;
            else if (phase == PH_BOV)  xcnt <= xcnt + 1'b1;
        end
    end

    assign scl = (phase == PH_SSU) || (phase == PH_SHD) || (phase == PH_BHI) ||
                 (phase == PH_BOV) || (phase == PH_PSU) ||
                 ((phase == PH_IDLE) && line_hi);

    assign sda_rise_stb = ((phase == PH_REL) && first_clk && (tick_idx == '0)) ||
                          ((phase == PH_PSU) && ph_end);
    assign sda_fall_stb = ((phase == PH_SSU) && ph_end) ||
                          ((phase == PH_PLO) && first_clk && (tick_idx == pos));
    assign sda_set_stb  = (phase == PH_BLO) && first_clk && (tick_idx == pos);
    assign sample_stb   = (phase == PH_BOV) && ph_end;
    assign seg_done     = seg_last;

    AST_SET_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        sda_set_stb |-> !scl); // R2
    AST_SAMPLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> scl); // R3
    AST_SDA_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sda_set_stb, sda_fall_stb, sda_rise_stb})); // R6
    AST_SCL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (scl != $past(scl)) |-> $past(load)); // R1
    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && req && kind == SEG_NONE) |=> (phase == PH_IDLE)); // R9

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tim_pkg::*;
#(
    parameter bit FLT_DOUBLE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hs_sel,
    input  logic [2:0]  flt_cycles,
    input  logic [31:0] fs_word1,
    input  logic [31:0] fs_word2,
    input  logic [31:0] fs_word3,
    input  logic [31:0] hs_word1,
    input  logic [31:0] hs_word2,
    input  logic [31:0] hs_word3,
    input  logic [31:0] hold_word,
    input  logic        req,
    input  logic [1:0]  req_kind,
    output logic        ready,
    output logic        scl,
    output logic        sda_fall_stb,
    output logic        sda_rise_stb,
    output logic        sda_set_stb,
    output logic        sample_stb,
    output logic        seg_done
);
    tim_set_t         sel;
    logic             load, first_clk, run_end;
    logic [CNT_W-1:0] div, lim, tick_idx;

    scl_tim_select u_select (
        .hs_sel (hs_sel),
        .fs_w1  (fs_word1),
        .fs_w2  (fs_word2),
        .fs_w3  (fs_word3),
        .hs_w1  (hs_word1),
        .hs_w2  (hs_word2),
        .hs_w3  (hs_word3),
        .hold_w (hold_word),
        .sel    (sel)
    );

    scl_tim_ticker u_ticker (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .div       (div),
        .lim       (lim),
        .first_clk (first_clk),
        .tick_idx  (tick_idx),
        .run_end   (run_end)
    );

    scl_tim_fsm #(.FLT_DOUBLE(FLT_DOUBLE)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .kind         (seg_kind_e'(req_kind)),
        .sel          (sel),
        .flt          (flt_cycles),
        .first_clk    (first_clk),
        .tick_idx     (tick_idx),
        .run_end      (run_end),
        .load         (load),
        .div          (div),
        .lim          (lim),
        .ready        (ready),
        .scl          (scl),
        .sda_fall_stb (sda_fall_stb),
        .sda_rise_stb (sda_rise_stb),
        .sda_set_stb  (sda_set_stb),
        .sample_stb   (sample_stb),
        .seg_done     (seg_done)
    );

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_sel = 1'b0;
    logic [2:0]  flt_cycles = 3'd0;
    logic [31:0] fs_word1, fs_word2, fs_word3, hs_word1, hs_word2, hs_word3, hold_word;
    logic        req = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        ready, scl, sda_fall_stb, sda_rise_stb, sda_set_stb, sample_stb, seg_done;

    // fld[set][i]: 0 div,1 lo,2 hi,3 start su,4 start hd,5 stop su,6 data su,7 release
    logic [7:0] fld [2][8];
    logic [7:0] hd   = 8'd0;
    logic [7:0] junk = 8'd0;
    int  checks = 0;
    int  fails  = 0;
    bit  line_m = 1'b1;
    int  q_kind [8];

    always #2 clk = ~clk;

    always_comb begin
        fs_word1  = {fld[0][3], fld[0][4], fld[0][5], junk};
        fs_word2  = {fld[0][6], junk, fld[0][1], fld[0][2]};
        fs_word3  = {junk, fld[0][0], junk, fld[0][7]};
        hs_word1  = {fld[1][3], fld[1][4], fld[1][5], junk};
        hs_word2  = {fld[1][6], junk, fld[1][1], fld[1][2]};
        hs_word3  = {junk, fld[1][0], junk, fld[1][7]};
        hold_word = {junk, junk, junk, hd};
    end

    scl_timing_gen u_scl_timing_gen (
        .clk(clk), .rst(rst), .hs_sel(hs_sel), .flt_cycles(flt_cycles),
        .fs_word1(fs_word1), .fs_word2(fs_word2), .fs_word3(fs_word3),
        .hs_word1(hs_word1), .hs_word2(hs_word2), .hs_word3(hs_word3),
        .hold_word(hold_word), .req(req), .req_kind(req_kind),
        .ready(ready), .scl(scl), .sda_fall_stb(sda_fall_stb),
        .sda_rise_stb(sda_rise_stb), .sda_set_stb(sda_set_stb),
        .sample_stb(sample_stb), .seg_done(seg_done)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        checks++;
        fails++;
        summary();
        $finish;
    end

    // Expected {ready, scl, fall, rise, set, sample, done} at clock k of a segment.
    function automatic logic [6:0] model(input int kind, input bit lh, input int s,
                                         input int f, input int k, output int len);
        int t, lo, room, pos, a, b, off;
        logic [6:0] e;
        t    = int'(fld[s][0]) + 1;
        lo   = int'(fld[s][1]);
        room = lo + 1 - int'(fld[s][6]);
        if (room < 0) room = 0;
        pos = int'(hd);
        if (pos > room) pos = room;
        if (pos > lo) pos = lo;
        e = '0;
        if (kind == 0) begin
            a = (lo + 1) * t;
            b = (int'(fld[s][2]) + 1) * t;
            len = a + b + 8 + 2 * f;
            e[5] = (k >= a);
            e[2] = (k == pos * t);
            e[1] = (k == len - 1);
        end else if (kind == 1) begin
            off = lh ? 0 : (int'(fld[s][7]) + 1) * t;
            a = (int'(fld[s][3]) + 1) * t;
            b = (int'(fld[s][4]) + 1) * t;
            len = off + a + b;
            e[5] = (k >= off);
            e[3] = !lh && (k == 0);
            e[4] = (k == off + a - 1);
        end else begin
            a = (lo + 1) * t;
            b = (int'(fld[s][5]) + 1) * t;
            len = a + b;
            e[5] = (k >= a);
            e[4] = (k == pos * t);
            e[3] = (k == len - 1);
        end
        e[0] = (k == len - 1);
        e[6] = (k == len - 1);
        return e;
    endfunction

    task automatic run_chain(input int n, input string tag, input bit flip_mid);
        int s, f, ns, nf, len, dummy;
        logic [6:0] exp_v, act_v;
        bit ok;
        @(negedge clk);
        req = 1'b1;
        req_kind = 2'(q_kind[0]);
        s = int'(hs_sel);
        f = int'(flt_cycles);
        ns = s;
        nf = f;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ok = 1'b1;
            void'(model(q_kind[i], line_m, s, f, 0, len));
            for (int k = 0; k < len; k++) begin
                exp_v = model(q_kind[i], line_m, s, f, k, dummy);
                act_v = {ready, scl, sda_fall_stb, sda_rise_stb, sda_set_stb, sample_stb, seg_done};
                if (act_v !== exp_v && ok) begin
                    $display("FAIL %s seg%0d kind%0d clock %0d: actual=%b expected=%b",
                             tag, i, q_kind[i], k, act_v, exp_v);
                    ok = 1'b0;
                end
                if (k == 0) req = 1'b0;
                if (flip_mid && k == 1) begin
                    hs_sel = ~hs_sel;
                    flt_cycles = ~flt_cycles;
                end
                if (k == len - 1 && i < n - 1) begin
                    req = 1'b1;
                    req_kind = 2'(q_kind[i + 1]);
                    ns = int'(hs_sel);
                    nf = int'(flt_cycles);
                end
                if (k < len - 1) @(negedge clk);
            end
            line_m = (q_kind[i] == 2);
            s = ns;
            f = nf;
            checks++;
            if (!ok) fails++;
        end
    endtask

    task automatic rand_set(input int s);
        fld[s][0] = 8'($urandom_range(0, 3));
        for (int i = 1; i < 8; i++) fld[s][i] = 8'($urandom_range(0, 12));
    endtask

    task automatic put_set(input int s, input int dv, input int lo, input int hi,
                           input int ssu, input int shd, input int psu,
                           input int dsu, input int rel);
        fld[s][0] = 8'(dv);  fld[s][1] = 8'(lo);  fld[s][2] = 8'(hi);
        fld[s][3] = 8'(ssu); fld[s][4] = 8'(shd); fld[s][5] = 8'(psu);
        fld[s][6] = 8'(dsu); fld[s][7] = 8'(rel);
    endtask

    initial begin
        int unsigned seed0;
        bit ok;
        seed0 = $urandom(32'd20240611);
        rand_set(0);
        rand_set(1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        checks++;
        if ({ready, scl, sda_fall_stb, sda_rise_stb, sda_set_stb, sample_stb, seg_done} !== 7'b1100000) begin
            fails++;
            $display("FAIL R10 reset outputs actual=%b expected=1100000",
                     {ready, scl, sda_fall_stb, sda_rise_stb, sda_set_stb, sample_stb, seg_done});
        end

        // R1: minimum counts, no prescale, no filter (period 2 + 8)
        put_set(0, 0, 0, 0, 0, 0, 0, 0, 0);
        hd = 8'd0; flt_cycles = 3'd0; hs_sel = 1'b0;
        q_kind[0] = 0;
        run_chain(1, "R1 minimum bit", 1'b0);

        // R1: maximum divider with filter cycles
        put_set(0, 255, 1, 0, 0, 0, 0, 0, 0);
        flt_cycles = 3'd7;
        run_chain(1, "R1 divider 255", 1'b0);

        // R2: data change clamped by setup (pos 2)
        put_set(0, 1, 5, 2, 1, 1, 1, 4, 1);
        hd = 8'd9; flt_cycles = 3'd2;
        run_chain(1, "R2 setup clamp", 1'b0);
        // R2: zero setup, huge hold (pos = last low tick)
        put_set(0, 2, 4, 1, 1, 1, 1, 0, 1);
        hd = 8'd200;
        run_chain(1, "R2 last low tick", 1'b0);
        // R2: setup longer than low phase (pos 0)
        put_set(0, 0, 3, 3, 1, 1, 1, 20, 1);
        hd = 8'd2;
        run_chain(1, "R2 setup overrun", 1'b0);

        // R4 R5 R6 R9: START from high, bit, repeated START, bit, STOP, back to back
        put_set(0, 1, 3, 2, 2, 3, 4, 1, 5);
        hd = 8'd1;
        q_kind[0] = 2; q_kind[1] = 1; q_kind[2] = 0; q_kind[3] = 1;
        q_kind[4] = 0; q_kind[5] = 2; q_kind[6] = 1;
        run_chain(7, "R4 R5 R6 R9 chained", 1'b0);

        // R8 R11: high-speed set chosen, then select and filter flipped mid-segment
        rand_set(0);
        put_set(1, 0, 2, 1, 3, 2, 1, 1, 2);
        junk = 8'hFF;
        hs_sel = 1'b1; flt_cycles = 3'd5;
        q_kind[0] = 0; q_kind[1] = 1; q_kind[2] = 2;
        run_chain(3, "R8 R11 hs set frozen", 1'b1);
        run_chain(3, "R8 R11 fs set frozen", 1'b1);

        // R9: kind 3 is ignored
        @(negedge clk);
        req = 1'b1; req_kind = 2'd3;
        @(negedge clk);
        req = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if ({ready, scl, sda_fall_stb, sda_rise_stb, sda_set_stb, sample_stb, seg_done}
                !== {1'b1, line_m, 5'b0}) ok = 1'b0;
            @(negedge clk);
        end
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R9 kind 3 not ignored actual=%b expected=%b",
                     {ready, scl, sda_fall_stb, sda_rise_stb, sda_set_stb, sample_stb, seg_done},
                     {1'b1, line_m, 5'b0});
        end

        // R7 and all timing requirements: random sets, junk in unused bits
        for (int r = 0; r < 40; r++) begin
            int n;
            rand_set(0);
            rand_set(1);
            hd = 8'($urandom_range(0, 12));
            junk = 8'($urandom);
            hs_sel = 1'($urandom);
            flt_cycles = 3'($urandom);
            n = $urandom_range(1, 4);
            for (int i = 0; i < n; i++) q_kind[i] = $urandom_range(0, 2);
            run_chain(n, "R7 R1 R2 R3 R4 R5 R6 random", 1'($urandom));
        end

        summary();
        $finish;
    end

endmodule